// File: doc/BRIEF.md
# USB IN Endpoint Control and Response Selector

This block holds the configuration and command state of one USB device endpoint and decides, for every IN poll from the host, what the endpoint sends back. A CPU-side port writes a packet-size code, an endpoint type and three one-shot commands: send a zero-length packet, empty the transmit FIFO, and stall the next poll. The endpoint side supplies a poll strobe, the number of bytes waiting in the transmit FIFO, and a strobe that marks a transaction as successfully completed.

For each poll the block registers a response one cycle later. The response is one of four kinds: a data packet with a length, a zero-length packet, a STALL handshake or a NAK. The data length is capped by the configured maximum packet size, and that cap is itself limited to the FIFO depth. Isochronous endpoints ignore the size code and send the whole FIFO content. The stall and zero-length commands clear themselves on protocol events, never through a CPU write of zero. The flush command becomes a single-cycle pulse towards the FIFO.

Top module: `usb_ep_ctrl`

## Requirements
- R1: The size code in cfg_wdata[6:5] selects a maximum packet of 8, 16, 32 or 64 bytes for codes 0, 1, 2 and 3. When that value exceeds FIFO_DEPTH the cap is FIFO_DEPTH. A non-isochronous data packet carries the smaller of fifo_level and the cap.
- R2: When the stored type is isochronous (code 1), the data length equals fifo_level and the size code has no effect.
- R3: The type in cfg_wdata[4:3] (0 control, 1 isochronous, 2 bulk, 3 interrupt) is stored and read back on cfg_rdata[4:3]. With EP_INDEX equal to 0, the stored type is always 0 (control). cfg_rdata mirrors the write layout: [6:5] size, [4:3] type, [2] zero-length request, [1] flush, [0] stall.
- R4: On a poll the response kind follows a fixed priority: STALL (code 3) when a stall is pending, else DATA (code 1) when fifo_level is non-zero, else ZLP (code 2) when a zero-length packet is requested, else NAK (code 0). Every kind other than DATA carries resp_len 0.
- R5: resp_valid is high in the cycle after each cycle in which in_poll is high, and is low otherwise. resp_kind and resp_len are valid while resp_valid is high.
- R6: Writing 1 to bit 0 sets the stall request. It clears when a poll is answered with STALL. Writing 0 to it has no effect. A write of 1 in the same cycle as the consuming poll leaves the request set.
- R7: Writing 1 to bit 2 sets the zero-length request. It clears only on txn_done following a poll answered with ZLP. A data response followed by txn_done, or a write of 0, leaves it set.
- R8: Writing 1 to bit 1 drives fifo_flush high for exactly the following cycle. Bit 1 always reads back 0.
- R9: After reset, cfg_rdata is 0, and resp_valid and fifo_flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 7 | Register read data |
| in_poll | input | 1 | Host IN poll strobe |
| fifo_level | input | LVL_W | Bytes waiting in the transmit FIFO |
| txn_done | input | 1 | Transaction completed successfully |
| resp_valid | output | 1 | Response strobe |
| resp_kind | output | 2 | Response kind: 0 NAK, 1 DATA, 2 ZLP, 3 STALL |
| resp_len | output | LVL_W | Data packet length in bytes |
| fifo_flush | output | 1 | Single-cycle FIFO empty request |

## Verification
The bench builds the block with FIFO_DEPTH at 24, so the two largest size codes are clamped and the two smallest are not. A second instance is built with EP_INDEX at 0 to show the forced control type. The small depth lets the bench sweep every size code, every type and every fill level from 0 to 24 with arithmetic expected lengths. Directed sequences then cover the command bits: their self-clearing, write-0 immunity and the write/poll collision.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   typedef enum logic [1:0] {
      RSP_NAK   = 2'd0,
      RSP_DATA  = 2'd1,
      RSP_ZLP   = 2'd2,
      RSP_STALL = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      EPT_CTRL = 2'd0,
      EPT_ISO  = 2'd1,
      EPT_BULK = 2'd2,
      EPT_INTR = 2'd3
   } ep_kind_e;

   localparam int unsigned CSR_W     = 7;
   localparam int unsigned BIT_STALL = 0;
   localparam int unsigned BIT_FLUSH = 1;
   localparam int unsigned BIT_ZLP   = 2;
   localparam int unsigned MIN_PKT   = 8;
   localparam int unsigned MAX_PKT   = 64;

   typedef struct packed {
      logic [1:0] size;
      ep_kind_e   kind;
      logic       zlp;
      logic       stall;
   } ep_cfg_t;

endpackage

// File: rtl/usb_ep_regs.sv
module usb_ep_regs
   import usb_ep_pkg::*;
#(
   parameter int unsigned EP_INDEX = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CSR_W-1:0] wdata,
   input  logic             stall_taken,
   input  logic             zlp_done,
   output ep_cfg_t          cfg,
   output logic             flush_pulse,
   output logic [CSR_W-1:0] rdata
);

   localparam bit IS_EP0 = (EP_INDEX == 0);

   ep_kind_e kind_wr;

   generate
      if (IS_EP0) begin : g_ep0
         logic [1:0] kind_ignored;
         always_comb kind_ignored = wdata[4:3];
         always_comb kind_wr = (kind_ignored == 2'd0) ? EPT_CTRL : EPT_CTRL;
      end else begin : g_epn
         always_comb kind_wr = ep_kind_e'(wdata[4:3]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg         <= '0;
         flush_pulse <= 1'b0;
      end else begin
         if (wr) begin
            cfg.size <= wdata[6:5];
            cfg.kind <= kind_wr;
         end
         cfg.zlp     <= (cfg.zlp & ~zlp_done) | (wr & wdata[BIT_ZLP]);
         cfg.stall   <= (cfg.stall & ~stall_taken) | (wr & wdata[BIT_STALL]);
         flush_pulse <= wr & wdata[BIT_FLUSH];
      end
   end

   always_comb rdata = {cfg.size, cfg.kind, cfg.zlp, 1'b0, cfg.stall};

endmodule

// File: rtl/usb_ep_lencap.sv
module usb_ep_lencap
   import usb_ep_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned LVL_W      = 7
) (
   input  logic [1:0]       size,
   input  ep_kind_e         kind,
   input  logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] len
);

   logic [31:0]      raw;
   logic [LVL_W-1:0] cap;

   always_comb raw = 32'(MIN_PKT) << size;

   generate
      if (FIFO_DEPTH >= MAX_PKT) begin : g_noclamp
         always_comb cap = LVL_W'(raw);
      end else begin : g_clamp
         always_comb begin
            if (raw > 32'(FIFO_DEPTH)) cap = LVL_W'(FIFO_DEPTH);
            else                       cap = LVL_W'(raw);
         end
      end
   endgenerate

   always_comb begin
      if (kind == EPT_ISO)  len = level;
      else if (level < cap) len = level;
      else                  len = cap;
   end

endmodule

// File: rtl/usb_ep_arbiter.sv
module usb_ep_arbiter
   import usb_ep_pkg::*;
#(
   parameter int unsigned LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll,
   input  logic             txn_done,
   input  logic             stall_req,
   input  logic             zlp_req,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] cap_len,
   output logic             stall_taken,
   output logic             zlp_done,
   output logic             resp_valid,
   output rsp_kind_e        resp_kind,
   output logic [LVL_W-1:0] resp_len
);

   rsp_kind_e pick;
   logic      last_zlp;

   always_comb begin
      if (stall_req)          pick = RSP_STALL;
      else if (level != '0)   pick = RSP_DATA;
      else if (zlp_req)       pick = RSP_ZLP;
      else                    pick = RSP_NAK;
   end

   always_comb stall_taken = poll & stall_req;
   always_comb zlp_done    = txn_done & last_zlp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_kind  <= RSP_NAK;
         resp_len   <= '0;
         last_zlp   <= 1'b0;
      end else begin
         resp_valid <= poll;
         if (poll) begin
            resp_kind <= pick;
            resp_len  <= (pick == RSP_DATA) ? cap_len : '0;
            last_zlp  <= (pick == RSP_ZLP);
         end else if (txn_done) begin
            last_zlp  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
   import usb_ep_pkg::*;
#(
   parameter  int unsigned FIFO_DEPTH = 64,
   parameter  int unsigned EP_INDEX   = 1,
   localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [6:0]       cfg_wdata,
   output logic [6:0]       cfg_rdata,
   input  logic             in_poll,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             txn_done,
   output logic             resp_valid,
   output logic [1:0]       resp_kind,
   output logic [LVL_W-1:0] resp_len,
   output logic             fifo_flush
);

   generate
      if (FIFO_DEPTH < MIN_PKT) begin : g_bad_depth
         $error("usb_ep_ctrl: FIFO_DEPTH must hold at least one minimum packet");
      end
      if (EP_INDEX > 15) begin : g_bad_index
         $error("usb_ep_ctrl: EP_INDEX out of the 0..15 range");
      end
   endgenerate

   ep_cfg_t          cfg;
   logic             stall_taken;
   logic             zlp_done;
   logic [LVL_W-1:0] cap_len;
   rsp_kind_e        kind_q;

   usb_ep_regs #(.EP_INDEX(EP_INDEX)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (cfg_wr),
      .wdata       (cfg_wdata),
      .stall_taken (stall_taken),
      .zlp_done    (zlp_done),
      .cfg         (cfg),
      .flush_pulse (fifo_flush),
      .rdata       (cfg_rdata)
   );

   usb_ep_lencap #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_lencap (
      .size  (cfg.size),
      .kind  (cfg.kind),
      .level (fifo_level),
      .len   (cap_len)
   );

   usb_ep_arbiter #(.LVL_W(LVL_W)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .poll        (in_poll),
      .txn_done    (txn_done),
      .stall_req   (cfg.stall),
      .zlp_req     (cfg.zlp),
      .level       (fifo_level),
      .cap_len     (cap_len),
      .stall_taken (stall_taken),
      .zlp_done    (zlp_done),
      .resp_valid  (resp_valid),
      .resp_kind   (kind_q),
      .resp_len    (resp_len)
   );

   always_comb resp_kind = kind_q;

endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk #(
   parameter int unsigned LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [6:0]       cfg_wdata,
   input logic [6:0]       cfg_rdata,
   input logic             in_poll,
   input logic [LVL_W-1:0] fifo_level,
   input logic             txn_done,
   input logic             resp_valid,
   input logic [1:0]       resp_kind,
   input logic [LVL_W-1:0] resp_len,
   input logic             fifo_flush
);

   AST_RESP_FOLLOWS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      in_poll |=> resp_valid); // R5

   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_poll |=> !resp_valid); // R5

   AST_DATA_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_poll && fifo_level != '0 && !cfg_rdata[0] |=>
         resp_kind == 2'd1 && resp_len != '0 && resp_len <= $past(fifo_level)); // R1

   AST_NONDATA_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_kind != 2'd1 |-> resp_len == '0); // R4

   AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      in_poll && cfg_rdata[0] |=> resp_kind == 2'd3); // R4

   AST_STALL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      in_poll && cfg_rdata[0] && !(cfg_wr && cfg_wdata[0]) |=> !cfg_rdata[0]); // R6

   AST_ZLP_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_rdata[2]) |-> $past(txn_done)); // R7

   AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && cfg_wdata[1] |=> fifo_flush); // R8

   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> $past(cfg_wr && cfg_wdata[1])); // R8

endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .in_poll    (in_poll),
   .fifo_level (fifo_level),
   .txn_done   (txn_done),
   .resp_valid (resp_valid),
   .resp_kind  (resp_kind),
   .resp_len   (resp_len),
   .fifo_flush (fifo_flush)
);

// File: tb/usb_ep_ctrl_bench.sv
module usb_ep_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 24;
   localparam int LW         = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [6:0]    cfg_wdata = '0;
   logic [6:0]    cfg_rdata, ep0_rdata;
   logic          in_poll = 1'b0;
   logic [LW-1:0] fifo_level = '0;
   logic          txn_done = 1'b0;
   logic          resp_valid, ep0_valid;
   logic [1:0]    resp_kind, ep0_kind;
   logic [LW-1:0] resp_len, ep0_len;
   logic          fifo_flush, ep0_flush;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_ep_ctrl #(.FIFO_DEPTH(DEPTH), .EP_INDEX(1)) u_usb_ep_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .in_poll(in_poll), .fifo_level(fifo_level),
      .txn_done(txn_done), .resp_valid(resp_valid), .resp_kind(resp_kind),
      .resp_len(resp_len), .fifo_flush(fifo_flush));

   usb_ep_ctrl #(.FIFO_DEPTH(DEPTH), .EP_INDEX(0)) u_ep0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(ep0_rdata), .in_poll(in_poll), .fifo_level(fifo_level),
      .txn_done(txn_done), .resp_valid(ep0_valid), .resp_kind(ep0_kind),
      .resp_len(ep0_len), .fifo_flush(ep0_flush));

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [6:0] d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic poll(input int lvl, input int exp_kind, input int exp_len, input string req);
      @(negedge clk);
      fifo_level = LW'(lvl);
      in_poll = 1'b1;
      @(negedge clk);
      in_poll = 1'b0;
      chk({req, " valid"}, int'(resp_valid), 1);
      chk({req, " kind"},  int'(resp_kind), exp_kind);
      chk({req, " len"},   int'(resp_len), exp_len);
   endtask

   task automatic done();
      @(negedge clk);
      txn_done = 1'b1;
      @(negedge clk);
      txn_done = 1'b0;
   endtask

   function automatic int exp_len(input int sz, input int ty, input int lvl);
      int cap;
      cap = 8 << sz;
      if (cap > DEPTH) cap = DEPTH;
      if (ty == 1) return lvl;
      return (lvl < cap) ? lvl : cap;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 rdata", int'(cfg_rdata), 0);
      chk("R9 valid", int'(resp_valid), 0);
      chk("R9 flush", int'(fifo_flush), 0);

      // R1 R2 R3 sweep: size x type x level
      for (int sz = 0; sz < 4; sz++) begin
         for (int ty = 0; ty < 4; ty++) begin
            wr(7'({sz[1:0], ty[1:0], 3'b000}));
            chk("R3 readback", int'(cfg_rdata), (sz << 5) | (ty << 3));
            chk("R3 ep0 type", int'(ep0_rdata[4:3]), 0);
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
               poll(lvl, (lvl > 0) ? 1 : 0, exp_len(sz, ty, lvl),
                    (ty == 1) ? "R2 iso" : "R1 cap");
            end
         end
      end

      // R5 no response without poll
      @(negedge clk);
      chk("R5 idle", int'(resp_valid), 0);

      // R6 stall: bulk, size 8
      wr(7'b00_10_0_0_1);
      chk("R6 stall set", int'(cfg_rdata[0]), 1);
      wr(7'b00_10_0_0_0);
      chk("R6 write0 keeps", int'(cfg_rdata[0]), 1);
      poll(10, 3, 0, "R4 stall first");
      chk("R6 stall cleared", int'(cfg_rdata[0]), 0);
      poll(10, 1, 8, "R6 after stall");

      // R6 collision: write 1 with the consuming poll
      wr(7'b00_10_0_0_1);
      @(negedge clk);
      fifo_level = LW'(3);
      in_poll = 1'b1;
      cfg_wr = 1'b1;
      cfg_wdata = 7'b00_10_0_0_1;
      @(negedge clk);
      in_poll = 1'b0;
      cfg_wr = 1'b0;
      cfg_wdata = '0;
      chk("R6 collision kind", int'(resp_kind), 3);
      chk("R6 collision kept", int'(cfg_rdata[0]), 1);
      poll(0, 3, 0, "R6 second stall");
      chk("R6 cleared again", int'(cfg_rdata[0]), 0);

      // R7 zero-length packet
      wr(7'b00_10_1_0_0);
      poll(0, 2, 0, "R7 zlp");
      chk("R7 held until done", int'(cfg_rdata[2]), 1);
      poll(0, 2, 0, "R7 zlp repeat");
      done();
      chk("R7 cleared by done", int'(cfg_rdata[2]), 0);
      poll(0, 0, 0, "R4 nak");
      wr(7'b00_10_1_0_0);
      poll(5, 1, 5, "R4 data over zlp");
      done();
      chk("R7 data done keeps", int'(cfg_rdata[2]), 1);
      wr(7'b00_10_0_0_0);
      chk("R7 write0 keeps", int'(cfg_rdata[2]), 1);
      wr(7'b00_10_0_0_1);
      poll(0, 3, 0, "R4 stall over zlp");
      chk("R7 stall keeps zlp", int'(cfg_rdata[2]), 1);
      poll(0, 2, 0, "R7 zlp after stall");
      done();
      chk("R7 final clear", int'(cfg_rdata[2]), 0);

      // R8 flush pulse
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = 7'b00_10_0_1_0;
      chk("R8 no early flush", int'(fifo_flush), 0);
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = '0;
      chk("R8 flush pulse", int'(fifo_flush), 1);
      chk("R8 reads zero", int'(cfg_rdata[1]), 0);
      @(negedge clk);
      chk("R8 single cycle", int'(fifo_flush), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule